// File: doc/BRIEF.md
# Iterative Subtract-Swap GCD Unit

This block finds the greatest common divisor of two integers by repeated subtraction. A pair of operands is accepted through a load port with ready and enable handshake signals. The unit then steps once per clock until the second working register reaches zero. That zero value marks both "idle" and "done", and the divisor can then be read from the result port while its ready flag is high.

Every clock the unit takes one of four steps. IDLE: the second register is zero and no load is requested, so nothing changes. LOAD: the unit is idle and a load is requested, so both registers take the operands. SWAP: the first register is greater than the nonzero second register. SUB: the first register is not greater than the nonzero second register. IDLE goes to LOAD on a request. LOAD goes to SWAP or SUB when the second operand is nonzero, and back to IDLE when it is zero. SWAP and SUB alternate until SUB leaves zero in the second register, which returns the unit to IDLE.

The parameter `MERGED` selects what SWAP does. With `MERGED=0` it only exchanges the two registers. With `MERGED=1` it also subtracts in the same cycle, so a result needs fewer cycles. Data width and signedness of the comparison are parameters too. The first operand must be nonzero, and operands are expected to be positive.

Top module: `gcd_iter`

## Requirements
- R1: After reset the second register is zero, so `load_rdy` and `gcd_rdy` are both 1.
- R2: When `load_en` is 1 while `load_rdy` is 1, the next cycle shows `gcd_out` equal to `opnd_a`, and the second register holds `opnd_b`.
- R3: A SUB step (first register <= second, second nonzero) subtracts the first register from the second and leaves `gcd_out` unchanged.
- R4: While idle with `load_en` at 0, `gcd_out` stays stable and both ready outputs stay 1.
- R5: With `MERGED=0`, a SWAP step (first register > second, second nonzero) exchanges the two registers. Loading 10 and 4 then takes exactly 6 step cycles.
- R6: With `MERGED=1`, a SWAP step loads the first register with the second and the second with their difference. Loading 10 and 4 then takes exactly 4 step cycles.
- R7: `load_rdy` and `gcd_rdy` are 1 exactly when the second register is zero, so they are 0 throughout a computation.
- R8: For `opnd_a` > 0 and `opnd_b` >= 0, once the ready flags return to 1, `gcd_out` equals gcd(`opnd_a`, `opnd_b`). With `opnd_b` = 0 this is `opnd_a`, shown one cycle after the load.
- R9: A `load_en` while `load_rdy` is 0 is ignored, and the computation in progress still ends with its own result.
- R10: For the same operands, the merged variant never needs more step cycles than the separate variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | WIDTH | First operand, must be nonzero |
| opnd_b | input | WIDTH | Second operand |
| load_en | input | 1 | Load request, accepted only while `load_rdy` is 1 |
| load_rdy | output | 1 | Unit is idle and can accept operands |
| gcd_out | output | WIDTH | Value of the first working register (the result when idle) |
| gcd_rdy | output | 1 | Result on `gcd_out` is valid |

## Verification
The final SUB step that empties the second register can fall in the same cycle as a new load request. The request is not yet honoured in that cycle, because ready is still low there. To provoke this, the bench holds `load_en` high without a break across a whole computation. It then judges that, in the first cycle ready is seen high, `gcd_out` still shows the old divisor. The new first operand must appear only one cycle later. Sweeps over all small operand pairs compare each result with a modulo-based divisor computed in the bench, and compare the cycle counts of the two variants.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SWAP = 2'd2,
        ST_SUB  = 2'd3
    } gcd_step_e;
endpackage

// File: rtl/gcd_step_sel.sv
module gcd_step_sel
    import gcd_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter bit SIGNED_OPS = 1'b1
) (
    input  logic [WIDTH-1:0] acc_q,
    input  logic [WIDTH-1:0] rem_q,
    input  logic             load_en,
    output gcd_step_e        step
);
    logic acc_gt_rem;
    logic rem_zero;

    assign rem_zero = (rem_q == '0);

    generate
        if (SIGNED_OPS) begin : g_signed_cmp
            assign acc_gt_rem = $signed(acc_q) > $signed(rem_q);
        end else begin : g_unsigned_cmp
            assign acc_gt_rem = acc_q > rem_q;
        end
    endgenerate

    always_comb begin
        step = ST_IDLE;
        if (rem_zero) begin
            if (load_en) step = ST_LOAD;
        end else if (acc_gt_rem) begin
            step = ST_SWAP;
        end else begin
            step = ST_SUB;
        end
    end
endmodule

// File: rtl/gcd_regs.sv
module gcd_regs
    import gcd_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter bit MERGED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gcd_step_e        step,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] acc_q,
    output logic [WIDTH-1:0] rem_q
);
    logic [WIDTH-1:0] swap_rem;

    generate
        if (MERGED) begin : g_merged
            assign swap_rem = acc_q - rem_q;
        end else begin : g_separate
            assign swap_rem = acc_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            rem_q <= '0;
        end else begin
            unique case (step)
                ST_IDLE: ;
                ST_LOAD: begin
                    acc_q <= opnd_a;
                    rem_q <= opnd_b;
                end
                ST_SWAP: begin
                    acc_q <= rem_q;
                    rem_q <= swap_rem;
                end
                ST_SUB: rem_q <= rem_q - acc_q;
            endcase
        end
    end

    // R3: a subtract step keeps the first register
    p_sub_keeps_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_SUB) |=> $stable(acc_q));

    // R5 / R6: a swap step moves the second register into the first
    p_swap_moves_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_SWAP) |=> (acc_q == $past(rem_q)));

    generate
        if (MERGED) begin : g_chk_merged
            p_merge_diff_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (step == ST_SWAP) |=> (rem_q == $past(acc_q) - $past(rem_q)));
        end else begin : g_chk_separate
            p_swap_exch_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (step == ST_SWAP) |=> (rem_q == $past(acc_q)));
        end
    endgenerate
endmodule

// File: rtl/gcd_iter.sv
module gcd_iter
    import gcd_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter bit SIGNED_OPS = 1'b1,
    parameter bit MERGED     = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             load_en,
    output logic             load_rdy,
    output logic [WIDTH-1:0] gcd_out,
    output logic             gcd_rdy
);
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] rem_q;
    gcd_step_e        step;
    logic             idle;

    gcd_step_sel #(.WIDTH(WIDTH), .SIGNED_OPS(SIGNED_OPS)) u_sel (
        .acc_q   (acc_q),
        .rem_q   (rem_q),
        .load_en (load_en),
        .step    (step)
    );

    gcd_regs #(.WIDTH(WIDTH), .MERGED(MERGED)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .acc_q  (acc_q),
        .rem_q  (rem_q)
    );

    assign idle = (rem_q == '0);

    always_comb begin
        load_rdy = idle;
        gcd_rdy  = idle;
        gcd_out  = acc_q;
    end

    // R2: an accepted load shows the first operand on the next cycle
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_rdy) |=> (gcd_out == $past(opnd_a)));

    // R4: an idle cycle without a load changes nothing
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rdy && !load_en) |=> ($stable(gcd_out) && load_rdy));

    // R9: a busy unit never takes a load step
    p_busy_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_rdy) |-> (step != ST_LOAD));
endmodule

// File: tb/tb_gcd_iter.sv
module tb_gcd_iter;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         load_en = 1'b0;
    logic         s_lrdy, s_rdy, m_lrdy, m_rdy;
    logic [W-1:0] s_out, m_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gcd_iter #(.WIDTH(W), .SIGNED_OPS(1'b1), .MERGED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .load_en(load_en), .load_rdy(s_lrdy), .gcd_out(s_out), .gcd_rdy(s_rdy));

    gcd_iter #(.WIDTH(W), .SIGNED_OPS(1'b1), .MERGED(1'b1)) dut_m (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .load_en(load_en), .load_rdy(m_lrdy), .gcd_out(m_out), .gcd_rdy(m_rdy));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_gcd(input int a, input int b);
        int p = a;
        int q = b;
        while (q != 0) begin
            int t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    // load on both units, then count step cycles of each
    task automatic run_pair(input int a, input int b, output int cs, output int cm);
        @(negedge clk);
        opnd_a = a[W-1:0];
        opnd_b = b[W-1:0];
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        cs = 0;
        cm = 0;
        while (!(s_rdy && m_rdy)) begin
            if (!s_rdy) cs++;
            if (!m_rdy) cm++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int cs, cm;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 load_rdy", int'(s_lrdy), 1);
        check("R1 gcd_rdy", int'(s_rdy), 1);
        check("R1 merged ready", int'(m_lrdy & m_rdy), 1);

        // R5 / R6: exact step counts for 10,4
        run_pair(10, 4, cs, cm);
        check("R5 separate cycles", cs, 6);
        check("R6 merged cycles", cm, 4);
        check("R8 10,4 result", int'(s_out), 2);

        // R4: idle hold
        repeat (3) begin
            @(negedge clk);
            check("R4 idle stable", int'(s_out), 2);
            check("R4 idle ready", int'(s_lrdy & s_rdy), 1);
        end

        // R2 / R3 / R7: load then one subtract step (4 <= 10)
        @(negedge clk);
        opnd_a = 8'd4;
        opnd_b = 8'd10;
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        check("R2 loaded a", int'(s_out), 4);
        check("R7 busy ready low", int'(s_lrdy | s_rdy), 0);
        @(negedge clk);
        check("R3 sub keeps out", int'(s_out), 4);
        while (!(s_rdy && m_rdy)) @(negedge clk);
        check("R8 4,10 result", int'(s_out), 2);

        // R5: swap step exchange visible on output (7,3 -> out 3)
        @(negedge clk);
        opnd_a = 8'd7;
        opnd_b = 8'd3;
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        check("R5 swap out", int'(s_out), 3);
        check("R6 merged swap out", int'(m_out), 3);
        while (!(s_rdy && m_rdy)) @(negedge clk);

        // R8: b == 0 gives a one cycle after load
        @(negedge clk);
        opnd_a = 8'd11;
        opnd_b = 8'd0;
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        check("R8 b zero out", int'(s_out), 11);
        check("R8 b zero ready", int'(s_rdy), 1);

        // R9: loads while busy are ignored
        @(negedge clk);
        opnd_a = 8'd12;
        opnd_b = 8'd18;
        load_en = 1'b1;
        @(negedge clk);
        opnd_a = 8'd5;
        opnd_b = 8'd7;
        repeat (2) @(negedge clk);
        load_en = 1'b0;
        while (!(s_rdy && m_rdy)) @(negedge clk);
        check("R9 separate ignores", int'(s_out), 6);
        check("R9 merged ignores", int'(m_out), 6);

        // load request held across the final step
        @(negedge clk);
        opnd_a = 8'd20;
        opnd_b = 8'd8;
        load_en = 1'b1;
        @(negedge clk);
        opnd_a = 8'd9;
        opnd_b = 8'd6;
        while (!s_rdy) @(negedge clk);
        check("R9 old result at ready", int'(s_out), 4);
        @(negedge clk);
        load_en = 1'b0;
        check("R2 held load taken", int'(s_out), 9);
        while (!(s_rdy && m_rdy)) @(negedge clk);
        check("R8 9,6 result", int'(s_out), 3);

        // sweep: results and cycle relation
        for (int a = 1; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_pair(a, b, cs, cm);
                check($sformatf("R8 sep %0d,%0d", a, b), int'(s_out), ref_gcd(a, b));
                check($sformatf("R8 mrg %0d,%0d", a, b), int'(m_out), ref_gcd(a, b));
                check($sformatf("R10 cycles %0d,%0d", a, b), int'(cm <= cs), 1);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule